// File: doc/BRIEF.md
# Serial Audio Playback Transmitter

This block plays stereo audio out of a small on-chip sample queue as a three-wire serial stream: a bit clock, a word-select (frame sync) line and a serial data line. Software or a DMA engine pushes left/right sample pairs through a valid/ready port. Each frame lasts 64 bit clocks and carries one pair, split into two 32-bit slots. Each slot holds a 16-bit sample, most significant bit first, followed by zero padding.

A two-bit mode input sets which side owns the clocks. In the first mode the block divides its own clock down to the bit clock and drives both clock lines. In the second it takes the bit clock from a pin and still drives word-select. In the third it follows both lines from an external master and locks its frame counter to the word-select edge. Static inputs choose standard or left-justified framing, which channel goes first, byte swapping of each sample, and what to send when the queue runs dry. A bit-clock enable halts the stream and restarts it cleanly at the beginning of a frame. A sticky underflow flag records any frame that started with nothing queued.

Top module: `serial_audio_tx`

## Requirements
- R1: With `clk_mode` = 0, the block drives `bclk_o` (`bclk_oe` = 1) with a period of `BCLK_DIV` clock cycles, and it drives word-select (`ws_oe` = 1).
- R2: A frame is 64 bit clocks long. Slot bits 0..15 carry the sample MSB first and bits 16..31 are zero. Data changes only on a falling edge of the bit clock and is stable at the rising edge.
- R3: With `fmt_msb_just` = 0, word-select is 0 for the left slot and 1 for the right slot, and it changes one bit clock before the first bit of the slot it announces.
- R4: With `fmt_msb_just` = 1, word-select is 1 for the left slot and 0 for the right slot, and it changes together with the first bit of the slot.
- R5: With `fmt_right_first` = 1, the right sample fills the first slot of each frame. Otherwise the left sample does.
- R6: With `fmt_byte_swap` = 1, the two bytes of each 16-bit sample are exchanged before it is sent.
- R7: A frame that starts with the queue empty repeats the previously sent pair when `fmt_hold_last` = 1, and sends zeros when it is 0.
- R8: `underflow` is set when a frame starts with the queue empty, stays set, and is cleared by a one-cycle pulse on `underflow_clr`.
- R9: The queue holds `FIFO_DEPTH` (8) pairs. `wr_ready` is 0 while it is full, and a pair offered while full is dropped.
- R10: While `bclk_en` = 0, `bclk_o` stays low and no frame starts. After `bclk_en` rises, the first frame carries the next queued pair with the first channel in the first slot.
- R11: With `clk_mode` = 1, the bit clock is taken from `bclk_i` (`bclk_oe` = 0) while word-select is driven, with the same framing as R2 to R5.
- R12: With `clk_mode` = 2 or 3, both lines are inputs (`bclk_oe` = `ws_oe` = 0). A word-select change to the first-channel level fixes the frame position, and no sample is taken before that lock.
- R13: After reset, `bclk_o`, `sd_o` and `underflow` are 0 and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and master clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_mode | input | 2 | 0 full master, 1 external bit clock, 2/3 slave |
| fmt_msb_just | input | 1 | 1 selects left-justified framing |
| fmt_right_first | input | 1 | 1 sends the right channel first |
| fmt_byte_swap | input | 1 | 1 swaps sample bytes |
| fmt_hold_last | input | 1 | 1 repeats the last pair on underflow |
| bclk_en | input | 1 | Bit clock run enable |
| wr_valid | input | 1 | Sample pair offered |
| wr_ready | output | 1 | Queue can accept a pair |
| wr_left | input | 16 | Left sample |
| wr_right | input | 16 | Right sample |
| underflow | output | 1 | Sticky empty-at-frame-start flag |
| underflow_clr | input | 1 | Clears `underflow` |
| bclk_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word-select |
| bclk_o | output | 1 | Generated bit clock |
| bclk_oe | output | 1 | Drive enable for the bit clock pin |
| ws_o | output | 1 | Generated word-select |
| ws_oe | output | 1 | Drive enable for the word-select pin |
| sd_o | output | 1 | Serial data |

## Verification
The master path is swept over all sixteen combinations of framing, channel order, byte swap and underflow policy. Each combination sends two queued frames and then one starved frame. The sample values make the two bytes of each sample differ and keep left distinct from right, so a wrong swap, a swapped channel order or a misplaced word-select edge changes bits that are compared one by one. A full-queue run sends nine frames after an attempted ninth write, which separates a dropped write from an accepted one. Short runs in the external-clock and slave modes check that the same bit layout follows clocks the block does not generate, and that nothing is sent before slave lock.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int SAMPLE_W   = 16;
    localparam int SLOT_W     = 2 * SAMPLE_W;   // padding assumes slot = 2 samples
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        CLK_MASTER    = 2'd0,
        CLK_EXT_BIT   = 2'd1,
        CLK_SLAVE     = 2'd2,
        CLK_SLAVE_ALT = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    typedef struct packed {
        logic msb_just;
        logic right_first;
        logic byte_swap;
        logic hold_last;
    } fmt_cfg_t;

    function automatic logic [SAMPLE_W-1:0] swap_bytes(input logic [SAMPLE_W-1:0] w);
        return {w[SAMPLE_W/2-1:0], w[SAMPLE_W-1:SAMPLE_W/2]};
    endfunction

    function automatic stereo_t swap_pair(input stereo_t s);
        stereo_t o;
        o.left  = swap_bytes(s.left);
        o.right = swap_bytes(s.right);
        return o;
    endfunction

    // upper half of the frame is the second slot
    function automatic logic slot_is_right(input logic [IDX_W-1:0] idx, input logic right_first);
        return idx[IDX_W-1] ^ right_first;
    endfunction

    // standard framing announces the next slot one bit early
    function automatic logic ws_for_index(input logic [IDX_W-1:0] idx, input fmt_cfg_t cfg);
        logic [IDX_W-1:0] look;
        look = cfg.msb_just ? idx : idx + IDX_W'(1);
        return slot_is_right(look, cfg.right_first) ^ cfg.msb_just;
    endfunction

    function automatic logic bit_for_index(input stereo_t s, input logic [IDX_W-1:0] idx,
                                           input logic right_first);
        logic [SAMPLE_W-1:0] word;
        logic [SAMPLE_W-1:0] shifted;
        logic [IDX_W-2:0]    pos;
        pos  = idx[IDX_W-2:0];
        word = slot_is_right(idx, right_first) ? s.right : s.left;
        if (pos[IDX_W-2])
            return 1'b0;
        shifted = word << pos[IDX_W-3:0];
        return shifted[SAMPLE_W-1];
    endfunction

endpackage

// File: rtl/sat_fifo.sv
module sat_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [W-1:0]                 wr_data,
    input  logic                         rd_en,
    output logic [W-1:0]                 rd_data,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push, pop;

    assign wr_ready = (count != CW'(DEPTH));
    assign empty    = (count == '0);
    assign push     = wr_valid && wr_ready;
    assign pop      = rd_en && !empty;
    assign rd_data  = mem[rp];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            if (push && !pop)
                count <= count + CW'(1);
            else if (pop && !push)
                count <= count - CW'(1);
        end
    end

endmodule

// File: rtl/sat_clk_front.sv
module sat_clk_front
    import sat_pkg::*;
#(
    parameter int BCLK_DIV = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  clk_mode_e mode,
    input  logic      bclk_en,
    input  logic      bclk_pin_i,
    input  logic      ws_pin_i,
    output logic      bclk_o,
    output logic      fall_ev,
    output logic      ws_in_sync
);
    localparam int CNT_W = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
    localparam int HALF  = BCLK_DIV / 2;

    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             last;
    logic             master;
    logic [2:0]       bsync;
    logic [1:0]       wsync;
    logic             ext_fall;

    assign master = (mode == CLK_MASTER);
    assign last   = (cnt == CNT_W'(BCLK_DIV-1));

    always_comb begin
        if (!bclk_en || !master || last)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            bclk_o <= 1'b0;
            bsync  <= '0;
            wsync  <= '0;
        end else begin
            cnt    <= cnt_nxt;
            bclk_o <= master && bclk_en && (cnt_nxt >= CNT_W'(HALF));
            bsync  <= {bsync[1:0], bclk_pin_i};
            wsync  <= {wsync[0], ws_pin_i};
        end
    end

    // bsync[1] and wsync[1] are the same depth, so word-select lines up with the edge
    assign ext_fall   = bsync[2] && !bsync[1];
    assign ws_in_sync = wsync[1];
    assign fall_ev    = bclk_en && (master ? last : ext_fall);

endmodule

// File: rtl/sat_framer.sv
module sat_framer
    import sat_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     slave,
    input  fmt_cfg_t cfg,
    input  logic     bclk_en,
    input  logic     fall_ev,
    input  logic     ws_in,
    input  stereo_t  head,
    input  logic     head_valid,
    output logic     pop,
    output logic     sd_o,
    output logic     ws_o,
    input  logic     uf_clr,
    output logic     underflow
);
    logic [IDX_W-1:0] idx, idx_nxt;
    logic             locked;
    logic             ws_prev;
    logic             first_ws;
    logic             resync;
    logic             start;
    stereo_t          cur, load_val, bits_src;

    assign first_ws = cfg.right_first ^ cfg.msb_just;
    assign resync   = slave && (ws_in != ws_prev) && (ws_in == first_ws);

    always_comb begin
        idx_nxt = idx;
        if (!bclk_en)
            idx_nxt = '1;
        else if (fall_ev) begin
            if (resync)
                idx_nxt = cfg.msb_just ? '0 : '1;
            else if (!slave || locked)
                idx_nxt = idx + IDX_W'(1);
        end
    end

    assign start = bclk_en && fall_ev && (idx_nxt == '0);
    assign pop   = start && head_valid;

    always_comb begin
        if (head_valid)
            load_val = cfg.byte_swap ? swap_pair(head) : head;
        else if (cfg.hold_last)
            load_val = cur;
        else
            load_val = '0;
    end

    assign bits_src = start ? load_val : cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '1;
            locked    <= 1'b0;
            ws_prev   <= 1'b0;
            cur       <= '0;
            sd_o      <= 1'b0;
            ws_o      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            idx  <= idx_nxt;
            sd_o <= bit_for_index(bits_src, idx_nxt, cfg.right_first);
            ws_o <= ws_for_index(idx_nxt, cfg);
            if (start)
                cur <= load_val;
            if (fall_ev)
                ws_prev <= ws_in;
            if (!bclk_en || !slave)
                locked <= 1'b0;
            else if (fall_ev && resync)
                locked <= 1'b1;
            if (start && !head_valid)
                underflow <= 1'b1;
            else if (uf_clr)
                underflow <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sat_pkg::*;
#(
    parameter int BCLK_DIV   = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          clk_mode,
    input  logic                fmt_msb_just,
    input  logic                fmt_right_first,
    input  logic                fmt_byte_swap,
    input  logic                fmt_hold_last,
    input  logic                bclk_en,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    output logic                underflow,
    input  logic                underflow_clr,
    input  logic                bclk_i,
    input  logic                ws_i,
    output logic                bclk_o,
    output logic                bclk_oe,
    output logic                ws_o,
    output logic                ws_oe,
    output logic                sd_o
);
    localparam int PAIR_W = $bits(stereo_t);
    localparam int CNT_W  = $clog2(FIFO_DEPTH+1);

    clk_mode_e         mode;
    fmt_cfg_t          cfg;
    stereo_t           wr_pair, head;
    logic [PAIR_W-1:0] fifo_rd;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_empty;
    logic              pop;
    logic              fall_ev;
    logic              ws_sync;

    assign mode          = clk_mode_e'(clk_mode);
    assign cfg.msb_just    = fmt_msb_just;
    assign cfg.right_first = fmt_right_first;
    assign cfg.byte_swap   = fmt_byte_swap;
    assign cfg.hold_last   = fmt_hold_last;
    assign wr_pair.left  = wr_left;
    assign wr_pair.right = wr_right;
    assign head          = fifo_rd;

    assign bclk_oe = (mode == CLK_MASTER);
    assign ws_oe   = !clk_mode[1];

    sat_fifo #(.DEPTH(FIFO_DEPTH), .W(PAIR_W)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_data  (wr_pair),
        .rd_en    (pop),
        .rd_data  (fifo_rd),
        .empty    (fifo_empty),
        .count    (fifo_cnt)
    );

    sat_clk_front #(.BCLK_DIV(BCLK_DIV)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .bclk_en    (bclk_en),
        .bclk_pin_i (bclk_i),
        .ws_pin_i   (ws_i),
        .bclk_o     (bclk_o),
        .fall_ev    (fall_ev),
        .ws_in_sync (ws_sync)
    );

    sat_framer u_frm (
        .clk        (clk),
        .rst        (rst),
        .slave      (clk_mode[1]),
        .cfg        (cfg),
        .bclk_en    (bclk_en),
        .fall_ev    (fall_ev),
        .ws_in      (ws_sync),
        .head       (head),
        .head_valid (!fifo_empty),
        .pop        (pop),
        .sd_o       (sd_o),
        .ws_o       (ws_o),
        .uf_clr     (underflow_clr),
        .underflow  (underflow)
    );

endmodule

// File: rtl/sat_tx_checker.sv
module sat_tx_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    clk_mode,
    input logic          bclk_en,
    input logic          bclk_o,
    input logic          bclk_oe,
    input logic          ws_oe,
    input logic          sd_o,
    input logic          wr_ready,
    input logic          underflow,
    input logic          underflow_clr,
    input logic [CW-1:0] fifo_cnt
);
    a_r1_master_drives: assert property (@(posedge clk) disable iff (rst)
        (clk_mode == 2'd0) |-> (bclk_oe && ws_oe));

    a_r12_slave_listens: assert property (@(posedge clk) disable iff (rst)
        clk_mode[1] |-> (!bclk_oe && !ws_oe));

    a_r10_idle_low: assert property (@(posedge clk) disable iff (rst)
        !bclk_en |=> !bclk_o);

    a_r2_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        ((clk_mode == 2'd0) && ($past(clk_mode) == 2'd0) && bclk_en && $past(bclk_en)
         && (sd_o != $past(sd_o))) |-> $fell(bclk_o));

    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (underflow && !underflow_clr) |=> underflow);

    a_r9_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CW'(DEPTH));

    a_r9_full_stall: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CW'(DEPTH)) |-> !wr_ready);

endmodule

bind serial_audio_tx sat_tx_checker #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .clk_mode      (clk_mode),
    .bclk_en       (bclk_en),
    .bclk_o        (bclk_o),
    .bclk_oe       (bclk_oe),
    .ws_oe         (ws_oe),
    .sd_o          (sd_o),
    .wr_ready      (wr_ready),
    .underflow     (underflow),
    .underflow_clr (underflow_clr),
    .fifo_cnt      (fifo_cnt)
);

// File: tb/serial_audio_tx_test.sv
module serial_audio_tx_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  clk_mode = 2'd0;
    logic        fmt_msb_just = 1'b0, fmt_right_first = 1'b0;
    logic        fmt_byte_swap = 1'b0, fmt_hold_last = 1'b0;
    logic        bclk_en = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [15:0] wr_left = '0, wr_right = '0;
    logic        underflow;
    logic        underflow_clr = 1'b0;
    logic        bclk_i = 1'b0, ws_i = 1'b0;
    logic        bclk_o, bclk_oe, ws_o, ws_oe, sd_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    serial_audio_tx #(.BCLK_DIV(4), .FIFO_DEPTH(8)) uut (
        .clk(clk), .rst(rst), .clk_mode(clk_mode),
        .fmt_msb_just(fmt_msb_just), .fmt_right_first(fmt_right_first),
        .fmt_byte_swap(fmt_byte_swap), .fmt_hold_last(fmt_hold_last),
        .bclk_en(bclk_en), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_left(wr_left), .wr_right(wr_right), .underflow(underflow),
        .underflow_clr(underflow_clr), .bclk_i(bclk_i), .ws_i(ws_i),
        .bclk_o(bclk_o), .bclk_oe(bclk_oe), .ws_o(ws_o), .ws_oe(ws_oe), .sd_o(sd_o)
    );

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish (got hang, expected completion)");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int e_right(int slot, bit rf);
        return ((slot / 32) == 1) ^ rf;
    endfunction

    function automatic int e_ws(int k, bit mj, bit rf);
        int s;
        s = mj ? k : (k + 1) % 64;
        return e_right(s, rf) ^ mj;
    endfunction

    function automatic int e_bit(int l, int r, int k, bit rf, bit sw);
        int w, b;
        w = (e_right(k, rf) != 0) ? r : l;
        if (sw) w = (w % 256) * 256 + (w / 256);
        b = k % 32;
        if (b >= 16) return 0;
        return (w >> (15 - b)) & 1;
    endfunction

    task automatic check_frame(input string tag, input int l, input int r,
                               input bit mj, input bit rf, input bit sw,
                               input logic [63:0] sdv, input logic [63:0] wsv);
        int bad, at, got, exp;
        bad = 0; at = 0; got = 0; exp = 0;
        for (int k = 0; k < 64; k++) begin
            int es, ew;
            es = e_bit(l, r, k, rf, sw);
            ew = e_ws(k, mj, rf);
            if (sdv[k] !== 1'(es) || wsv[k] !== 1'(ew)) begin
                if (bad == 0) begin
                    at = k; got = {sdv[k], wsv[k]}; exp = es * 2 + ew;
                end
                bad++;
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_err++;
            $display("FAIL %s: bit %0d {sd,ws} got %0d expected %0d (%0d bad bits)",
                     tag, at, got, exp, bad);
        end
    endtask

    task automatic wait_rise(output int cyc);
        logic p;
        cyc = 0;
        p = bclk_o;
        @(negedge clk); cyc++;
        while (!(bclk_o && !p)) begin
            p = bclk_o;
            @(negedge clk); cyc++;
        end
    endtask

    task automatic cap_master(output logic [63:0] sdv, output logic [63:0] wsv);
        int c;
        for (int k = 0; k < 64; k++) begin
            wait_rise(c);
            sdv[k] = sd_o;
            wsv[k] = ws_o;
        end
    endtask

    task automatic ext_bit(input int wsv_drive, output logic sdb, output logic wsb);
        bclk_i = 1'b0;
        ws_i   = 1'(wsv_drive);
        repeat (8) @(negedge clk);
        bclk_i = 1'b1;
        repeat (8) @(negedge clk);
        sdb = sd_o;
        wsb = ws_o;
    endtask

    task automatic write_pair(input int l, input int r);
        @(negedge clk);
        wr_valid = 1'b1; wr_left = 16'(l); wr_right = 16'(r);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); underflow_clr = 1'b1;
        @(negedge clk); underflow_clr = 1'b0;
    endtask

    initial begin
        logic [63:0] sdv, wsv;
        int cyc, nz;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R13 reset state
        check(bclk_o == 1'b0, "R13 bclk_o", int'(bclk_o), 0);
        check(sd_o == 1'b0, "R13 sd_o", int'(sd_o), 0);
        check(wr_ready == 1'b1, "R13 wr_ready", int'(wr_ready), 1);
        check(underflow == 1'b0, "R13 underflow", int'(underflow), 0);

        // R10 idle: no clock, no frame starts with an empty queue
        nz = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (bclk_o) nz++;
        end
        check(nz == 0, "R10 idle clock", nz, 0);
        check(underflow == 1'b0, "R10 no start while stopped", int'(underflow), 0);
        check(bclk_oe && ws_oe, "R1 drive enables", int'({bclk_oe, ws_oe}), 3);

        // R1 period, R8 empty start
        bclk_en = 1'b1;
        wait_rise(cyc);
        wait_rise(cyc);
        check(cyc == 4, "R1 bit clock period", cyc, 4);
        check(underflow == 1'b1, "R8 flag on empty start", int'(underflow), 1);
        bclk_en = 1'b0;
        pulse_clr();
        check(underflow == 1'b0, "R8 clear pulse", int'(underflow), 0);

        // Sweep all option combinations
        for (int c = 0; c < 16; c++) begin
            bit mj, rf, sw, hl;
            int l1, r1, l2, r2;
            mj = c[0]; rf = c[1]; sw = c[2]; hl = c[3];
            fmt_msb_just = mj; fmt_right_first = rf;
            fmt_byte_swap = sw; fmt_hold_last = hl;
            l1 = (c * 3001 + 4660) % 65536;  r1 = (c * 7919 + 43981) % 65536;
            l2 = (c * 1237 + 22136) % 65536; r2 = (c * 911 + 39612) % 65536;
            write_pair(l1, r1);
            write_pair(l2, r2);
            @(negedge clk);
            bclk_en = 1'b1;
            wait_rise(cyc);
            cap_master(sdv, wsv);
            if (sw)      check_frame("R6 byte swap frame", l1, r1, mj, rf, sw, sdv, wsv);
            else if (mj) check_frame("R4 justified frame", l1, r1, mj, rf, sw, sdv, wsv);
            else         check_frame("R3 standard frame", l1, r1, mj, rf, sw, sdv, wsv);
            cap_master(sdv, wsv);
            if (rf) check_frame("R5 right first frame", l2, r2, mj, rf, sw, sdv, wsv);
            else    check_frame("R2 second frame", l2, r2, mj, rf, sw, sdv, wsv);
            check(underflow == 1'b0, "R8 no flag with data", int'(underflow), 0);
            cap_master(sdv, wsv);
            bclk_en = 1'b0;
            if (hl) check_frame("R7 repeat on underflow", l2, r2, mj, rf, sw, sdv, wsv);
            else    check_frame("R7 zero on underflow", 0, 0, mj, rf, 1'b0, sdv, wsv);
            check(underflow == 1'b1, "R8 flag after starved frame", int'(underflow), 1);
            pulse_clr();
            check(underflow == 1'b0, "R8 cleared", int'(underflow), 0);
        end

        // R9 full queue, dropped write
        fmt_msb_just = 1'b0; fmt_right_first = 1'b0;
        fmt_byte_swap = 1'b0; fmt_hold_last = 1'b1;
        for (int i = 0; i < 8; i++) write_pair(1000 + i * 4111, 50000 - i * 3333);
        check(wr_ready == 1'b0, "R9 ready low when full", int'(wr_ready), 0);
        write_pair(777, 888);
        bclk_en = 1'b1;
        wait_rise(cyc);
        for (int i = 0; i < 8; i++) begin
            cap_master(sdv, wsv);
            check_frame("R9 queued frame", 1000 + i * 4111, 50000 - i * 3333,
                        1'b0, 1'b0, 1'b0, sdv, wsv);
        end
        cap_master(sdv, wsv);
        bclk_en = 1'b0;
        check_frame("R9 dropped write not sent", 1000 + 7 * 4111, 50000 - 7 * 3333,
                    1'b0, 1'b0, 1'b0, sdv, wsv);
        pulse_clr();

        // R11 external bit clock
        clk_mode = 2'd1;
        fmt_hold_last = 1'b0;
        write_pair(41394, 4951);
        @(negedge clk);
        check(!bclk_oe && ws_oe, "R11 drive enables", int'({bclk_oe, ws_oe}), 1);
        bclk_en = 1'b1;
        begin
            logic sb, wb;
            ext_bit(0, sb, wb);
            for (int k = 0; k < 64; k++) begin
                ext_bit(0, sb, wb);
                sdv[k] = sb; wsv[k] = wb;
            end
        end
        check_frame("R11 external clock frame", 41394, 4951, 1'b0, 1'b0, 1'b0, sdv, wsv);
        bclk_en = 1'b0;
        bclk_i = 1'b0;

        // R12 slave: lock on word-select then send
        clk_mode = 2'd2;
        write_pair(25923, 61455);
        @(negedge clk);
        check(!bclk_oe && !ws_oe, "R12 drive enables", int'({bclk_oe, ws_oe}), 0);
        bclk_en = 1'b1;
        begin
            logic sb, wb;
            nz = 0;
            for (int k = 0; k < 64; k++) begin
                ext_bit(e_ws(k, 1'b0, 1'b0), sb, wb);
                if (sb) nz++;
            end
            check(nz == 0, "R12 silent before lock", nz, 0);
            for (int k = 0; k < 64; k++) begin
                ext_bit(e_ws(k, 1'b0, 1'b0), sb, wb);
                sdv[k] = sb;
                wsv[k] = 1'(e_ws(k, 1'b0, 1'b0));
            end
        end
        check_frame("R12 slave frame", 25923, 61455, 1'b0, 1'b0, 1'b0, sdv, wsv);
        bclk_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule